// File: doc/BRIEF.md
# Gated Timer/Counter With Selectable Geometry

This block is one timer/counter built around a pair of byte-wide count registers. Each count step comes from one of two sources. The first is an internal timebase that ticks once every 4 or once every 12 system clocks. The second is a falling edge on an external count pin, which passes through a synchronizer first. The mode field sets how the two bytes form the count. It can be a 13-bit counter, a full 16-bit counter, or an 8-bit counter that reloads itself from the high byte. A fourth mode value freezes the count.

Counting needs the run bit. When the gate option is on, a synchronized external gate pin must also be high. This lets hardware measure the width of a pulse on the gate pin. Overflow sets a sticky flag. Software clears the flag by writing the control register, or the interrupt controller clears it with an acknowledge strobe. An interrupt request is raised while the flag is set and the interrupt enable bit is on.

Top module: `tmr_gated_top`

## Requirements
- R1: After reset the low byte, the high byte and the control register read 0, the overflow flag is 0 and the interrupt request is low.
- R2: Register map. Address 0 is the low byte, address 1 is the high byte, address 2 is the control register and address 3 reads 0. The control bits are: [1:0] mode, [2] external-count select, [3] gate enable, [4] fast timebase, [5] run, [6] interrupt enable, [7] overflow flag. All of them read back as written, except that bit 7 shows the flag.
- R3: In mode 1 the two bytes form a 16-bit count, with the high byte as the upper half. A step from FFFFh gives 0000h and sets the flag.
- R4: In mode 0 the count is 13 bits. The upper part is all 8 bits of the high byte and the lower part is the low byte bits [4:0]. Low byte bits [7:5] keep their value. A step from the all-ones value gives zero and sets the flag.
- R5: In mode 2 the low byte counts. A step from FFh loads the low byte with the high byte and sets the flag. The high byte never changes by counting.
- R6: In mode 3 neither byte changes and the flag is never set, whatever the count source does.
- R7: No count occurs while run is 0. With the gate enabled, no count occurs while the gate pin is low, and counting resumes once the gate pin is high.
- R8: With external-count select at 0, the count steps once every 4 clocks when the fast bit is 1, and once every 12 clocks when the fast bit is 0.
- R9: With external-count select at 1, each 1-to-0 transition of the count pin adds exactly one step, a few clocks after the edge.
- R10: A write to either count byte takes effect in full. In the same cycle the pending step is dropped.
- R11: An acknowledge pulse or a control write with bit 7 at 0 clears the flag. An overflow in the same cycle keeps the flag set.
- R12: The interrupt request equals the flag ANDed with the interrupt enable bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | BYTE_W | Write data |
| reg_rdata | output | BYTE_W | Read data for reg_addr |
| cnt_pin | input | 1 | External count pulses, asynchronous |
| gate_pin | input | 1 | External gate level, asynchronous |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq_req | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters. These are byte width 8, a 5-bit low field for mode 0, timebase dividers 4 and 12, and two synchronizer stages. With 8-bit bytes, every geometry reaches its wrap point within a couple of external pulses after a preload, which keeps the reload and 13-bit carry cases fully deterministic. The small dividers let the bench measure the exact interval between timer steps at both rates within a few dozen clocks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   typedef enum logic [1:0] {
      MODE_13B    = 2'd0,
      MODE_16B    = 2'd1,
      MODE_RELOAD = 2'd2,
      MODE_HOLD   = 2'd3
   } tmr_mode_e;

   localparam logic [1:0] ADDR_LO  = 2'd0;
   localparam logic [1:0] ADDR_HI  = 2'd1;
   localparam logic [1:0] ADDR_CTL = 2'd2;

   // control register without the flag bit (bit 7 lives separately)
   typedef struct packed {
      logic      ien;
      logic      run;
      logic      fast;
      logic      gate;
      logic      ext;
      tmr_mode_e mode;
   } tmr_ctrl_t;

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sr;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sr[g] <= 1'b0;
               else        sr[g] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sr[g] <= 1'b0;
               else        sr[g] <= sr[g-1];
            end
         end
      end
   endgenerate

   assign q = sr[STAGES-1];
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int DIV_FAST = 4,
   parameter int DIV_SLOW = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fast,
   output logic tick
);
   localparam int CW = (DIV_SLOW > 1) ? $clog2(DIV_SLOW) : 1;
   localparam logic [CW-1:0] LIM_F = CW'(DIV_FAST - 1);
   localparam logic [CW-1:0] LIM_S = CW'(DIV_SLOW - 1);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] lim;

   assign lim  = fast ? LIM_F : LIM_S;
   // ">=" so a switch to the fast rate from a high count wraps at once
   assign tick = (cnt_q >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (tick) cnt_q <= '0;
      else           cnt_q <= cnt_q + CW'(1);
   end
endmodule

// File: rtl/tmr_count_step.sv
module tmr_count_step
   import tmr_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int LO_PART_W = 5
) (
   input  tmr_mode_e         mode,
   input  logic [BYTE_W-1:0] lo_q,
   input  logic [BYTE_W-1:0] hi_q,
   output logic [BYTE_W-1:0] lo_d,
   output logic [BYTE_W-1:0] hi_d,
   output logic              wrap
);
   localparam int W13 = BYTE_W + LO_PART_W;
   localparam int W16 = 2 * BYTE_W;

   logic [W13-1:0] p13, s13;
   logic [W16-1:0] p16, s16;

   always_comb begin
      p13  = {hi_q, lo_q[LO_PART_W-1:0]};
      s13  = p13 + W13'(1);
      p16  = {hi_q, lo_q};
      s16  = p16 + W16'(1);
      lo_d = lo_q;
      hi_d = hi_q;
      wrap = 1'b0;
      case (mode)
         MODE_13B: begin
            lo_d = {lo_q[BYTE_W-1:LO_PART_W], s13[LO_PART_W-1:0]};
            hi_d = s13[W13-1:LO_PART_W];
            wrap = &p13;
         end
         MODE_16B: begin
            lo_d = s16[BYTE_W-1:0];
            hi_d = s16[W16-1:BYTE_W];
            wrap = &p16;
         end
         MODE_RELOAD: begin
            if (&lo_q) begin
               lo_d = hi_q;
               wrap = 1'b1;
            end else begin
               lo_d = lo_q + BYTE_W'(1);
            end
         end
         default: begin
            lo_d = lo_q;
            hi_d = hi_q;
            wrap = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/tmr_gated_top.sv
module tmr_gated_top
   import tmr_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int LO_PART_W   = 5,
   parameter int DIV_FAST    = 4,
   parameter int DIV_SLOW    = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [BYTE_W-1:0] reg_wdata,
   output logic [BYTE_W-1:0] reg_rdata,
   input  logic              cnt_pin,
   input  logic              gate_pin,
   input  logic              irq_ack,
   output logic              ovf_flag,
   output logic              irq_req
);
   localparam int CTL_W = $bits(tmr_ctrl_t);

   generate
      if (BYTE_W < 8) begin : g_bad_byte
         $error("BYTE_W must be at least 8");
      end
      if (LO_PART_W < 1 || LO_PART_W >= BYTE_W) begin : g_bad_lo
         $error("LO_PART_W must lie in 1..BYTE_W-1");
      end
      if (DIV_FAST < 1 || DIV_SLOW < DIV_FAST) begin : g_bad_div
         $error("need 1 <= DIV_FAST <= DIV_SLOW");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   tmr_ctrl_t         ctrl_q;
   logic              flag_q;
   logic [BYTE_W-1:0] lo_q, hi_q, lo_d, hi_d;
   logic              wrap;
   logic              cnt_s, gate_s, cnt_prev_q, cnt_fall;
   logic              tick, run_ok, step_src, inc, ovf_hit;
   logic              wr_lo, wr_hi, wr_ctl;

   tmr_sync #(.STAGES(SYNC_STAGES)) u_sync_cnt (
      .clk(clk), .rst_n(rst_n), .d(cnt_pin), .q(cnt_s)
   );

   tmr_sync #(.STAGES(SYNC_STAGES)) u_sync_gate (
      .clk(clk), .rst_n(rst_n), .d(gate_pin), .q(gate_s)
   );

   tmr_prescale #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_pre (
      .clk(clk), .rst_n(rst_n), .fast(ctrl_q.fast), .tick(tick)
   );

   tmr_count_step #(.BYTE_W(BYTE_W), .LO_PART_W(LO_PART_W)) u_step (
      .mode(ctrl_q.mode), .lo_q(lo_q), .hi_q(hi_q),
      .lo_d(lo_d), .hi_d(hi_d), .wrap(wrap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_prev_q <= 1'b0;
      else        cnt_prev_q <= cnt_s;
   end

   assign cnt_fall = cnt_prev_q & ~cnt_s;
   assign wr_lo    = reg_wr && (reg_addr == ADDR_LO);
   assign wr_hi    = reg_wr && (reg_addr == ADDR_HI);
   assign wr_ctl   = reg_wr && (reg_addr == ADDR_CTL);
   assign run_ok   = ctrl_q.run && (!ctrl_q.gate || gate_s);
   assign step_src = ctrl_q.ext ? cnt_fall : tick;
   assign inc      = run_ok && step_src && (ctrl_q.mode != MODE_HOLD)
                     && !wr_lo && !wr_hi;
   assign ovf_hit  = inc && wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         if (wr_lo)    lo_q <= reg_wdata;
         else if (inc) lo_q <= lo_d;
         if (wr_hi)    hi_q <= reg_wdata;
         else if (inc) hi_q <= hi_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         flag_q <= 1'b0;
      end else begin
         if (wr_ctl) ctrl_q <= tmr_ctrl_t'(reg_wdata[CTL_W-1:0]);
         if (ovf_hit)      flag_q <= 1'b1;
         else if (irq_ack) flag_q <= 1'b0;
         else if (wr_ctl)  flag_q <= reg_wdata[CTL_W];
      end
   end

   always_comb begin
      case (reg_addr)
         ADDR_LO:  reg_rdata = lo_q;
         ADDR_HI:  reg_rdata = hi_q;
         ADDR_CTL: reg_rdata = BYTE_W'({flag_q, ctrl_q});
         default:  reg_rdata = '0;
      endcase
   end

   assign ovf_flag = flag_q;
   assign irq_req  = flag_q & ctrl_q.ien;
endmodule

// File: rtl/tmr_gated_chk.sv
module tmr_gated_chk #(
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_lo,
   input logic              wr_hi,
   input logic              wr_ctl,
   input logic [BYTE_W-1:0] wdata,
   input logic [1:0]        mode,
   input logic              run,
   input logic              ovf_hit,
   input logic              irq_ack,
   input logic              flag,
   input logic [BYTE_W-1:0] lo,
   input logic [BYTE_W-1:0] hi
);
   AST_WRITE_WINS_LO: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> (lo == $past(wdata)));  // R10
   AST_WRITE_WINS_HI: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi |=> (hi == $past(wdata)));  // R10
   AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd3 && !wr_lo && !wr_hi) |=> ($stable(lo) && $stable(hi)));  // R6
   AST_HOLD_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd3 && !flag && !wr_ctl) |=> !flag);  // R6
   AST_RELOAD_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd2 && !wr_hi) |=> $stable(hi));  // R5
   AST_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !wr_lo && !wr_hi) |=> ($stable(lo) && $stable(hi)));  // R7
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !ovf_hit) |=> !flag);  // R11
   AST_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_hit |=> flag);  // R11
endmodule

bind tmr_gated_top tmr_gated_chk #(.BYTE_W(BYTE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_ctl(wr_ctl),
   .wdata(reg_wdata), .mode(ctrl_q.mode), .run(ctrl_q.run),
   .ovf_hit(ovf_hit), .irq_ack(irq_ack), .flag(flag_q), .lo(lo_q), .hi(hi_q)
);

// File: tb/tmr_gated_top_tb.sv
module tmr_gated_top_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       cnt_pin = 1'b1;
   logic       gate_pin = 1'b0;
   logic       irq_ack = 1'b0;
   logic       ovf_flag, irq_req;
   int         total = 0;
   int         bad = 0;

   always #4 clk = ~clk;

   tmr_gated_top dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_pin(cnt_pin),
      .gate_pin(gate_pin), .irq_ack(irq_ack), .ovf_flag(ovf_flag),
      .irq_req(irq_req)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      reg_addr = a;
      #1;
      v = int'(reg_rdata);
   endtask

   task automatic pulse();
      @(negedge clk); cnt_pin = 1'b0;
      repeat (4) @(negedge clk);
      cnt_pin = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      int v;
      rd(2'd0, v); chk("R1 lo", v, 0);
      rd(2'd1, v); chk("R1 hi", v, 0);
      rd(2'd2, v); chk("R1 ctl", v, 0);
      chk("R1 flag", ovf_flag, 0);
      chk("R1 irq", irq_req, 0);
   endtask

   task automatic t_regmap();
      int v;
      wr(2'd2, 8'h5A); rd(2'd2, v); chk("R2 ctl readback", v, 8'h5A);
      wr(2'd0, 8'h33); rd(2'd0, v); chk("R2 lo readback", v, 8'h33);
      wr(2'd1, 8'hC4); rd(2'd1, v); chk("R2 hi readback", v, 8'hC4);
      rd(2'd3, v); chk("R2 addr3", v, 0);
      wr(2'd2, 8'h00);
   endtask

   task automatic t_mode1();
      int v;
      wr(2'd0, 8'hFE); wr(2'd1, 8'hFF);
      wr(2'd2, 8'h65);
      pulse();
      rd(2'd0, v); chk("R3 lo FF", v, 8'hFF);
      chk("R3 no flag yet", ovf_flag, 0);
      pulse();
      rd(2'd0, v); chk("R3 lo wrap", v, 0);
      rd(2'd1, v); chk("R3 hi wrap", v, 0);
      chk("R3 flag", ovf_flag, 1);
      chk("R12 irq on", irq_req, 1);
      rd(2'd2, v); chk("R2 flag bit7", v, 8'hE5);
      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
      chk("R11 ack clears", ovf_flag, 0);
      chk("R12 irq off", irq_req, 0);
      wr(2'd2, 8'h00);
   endtask

   task automatic t_mode0();
      int v;
      wr(2'd0, 8'hFE); wr(2'd1, 8'hFF);
      wr(2'd2, 8'h24);
      pulse();
      rd(2'd0, v); chk("R4 lo step", v, 8'hFF);
      chk("R4 no flag", ovf_flag, 0);
      pulse();
      rd(2'd0, v); chk("R4 lo wrap keeps [7:5]", v, 8'hE0);
      rd(2'd1, v); chk("R4 hi wrap", v, 0);
      chk("R4 flag", ovf_flag, 1);
      chk("R12 irq masked", irq_req, 0);
      pulse();
      rd(2'd0, v); chk("R9 single step", v, 8'hE1);
      wr(2'd2, 8'h24);
      chk("R11 write clears", ovf_flag, 0);
      wr(2'd2, 8'h00);
   endtask

   task automatic t_mode2();
      int v;
      wr(2'd1, 8'hF0); wr(2'd0, 8'hFE);
      wr(2'd2, 8'h26);
      pulse();
      rd(2'd0, v); chk("R5 lo FF", v, 8'hFF);
      pulse();
      rd(2'd0, v); chk("R5 reload", v, 8'hF0);
      rd(2'd1, v); chk("R5 hi kept", v, 8'hF0);
      chk("R5 flag", ovf_flag, 1);
      pulse();
      rd(2'd0, v); chk("R5 continue", v, 8'hF1);
      wr(2'd2, 8'h00);
   endtask

   task automatic t_mode3();
      int v;
      wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
      wr(2'd2, 8'h27);
      for (int i = 0; i < 3; i++) pulse();
      rd(2'd0, v); chk("R6 lo frozen", v, 8'hFF);
      rd(2'd1, v); chk("R6 hi frozen", v, 8'hFF);
      chk("R6 no flag", ovf_flag, 0);
      wr(2'd2, 8'h00);
   endtask

   task automatic t_enable();
      int v;
      wr(2'd0, 8'h00); wr(2'd1, 8'h00);
      wr(2'd2, 8'h05);
      pulse(); pulse();
      rd(2'd0, v); chk("R7 run off", v, 0);
      gate_pin = 1'b0;
      wr(2'd2, 8'h2D);
      pulse(); pulse();
      rd(2'd0, v); chk("R7 gate low", v, 0);
      gate_pin = 1'b1;
      repeat (4) @(negedge clk);
      pulse(); pulse();
      rd(2'd0, v); chk("R7 gate high", v, 2);
      gate_pin = 1'b0;
      wr(2'd2, 8'h00);
   endtask

   task automatic measure(output int gap);
      int v0, v;
      int n;
      gap = 0;
      rd(2'd0, v0);
      n = 0;
      do begin @(negedge clk); rd(2'd0, v); n++; end
      while (v == v0 && n < 100);
      v0 = v; n = 0;
      do begin @(negedge clk); rd(2'd0, v); n++; end
      while (v == v0 && n < 100);
      gap = n;
   endtask

   task automatic t_timebase();
      int g;
      wr(2'd0, 8'h00); wr(2'd1, 8'h00);
      wr(2'd2, 8'h31);
      measure(g); chk("R8 fast gap", g, 4);
      wr(2'd2, 8'h21);
      measure(g); chk("R8 slow gap", g, 12);
      wr(2'd2, 8'h00);
   endtask

   task automatic t_priority();
      int v;
      wr(2'd1, 8'h00);
      wr(2'd2, 8'h31);
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h40 + 8'(i);
         @(negedge clk);
         reg_wr = 1'b0;
         rd(2'd0, v); chk("R10 write wins", v, 8'h40 + i);
      end
      rd(2'd1, v); chk("R10 hi untouched", v, 0);
      wr(2'd2, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_regmap();
      t_mode1();
      t_mode0();
      t_mode2();
      t_mode3();
      t_enable();
      t_timebase();
      t_priority();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule